// File: doc/BRIEF.md
# Descriptor-Chain Lookup-Table Refill Engine

This block fills a two-dimensional translation lookup table from memory without processor involvement. Software writes the byte address of a first descriptor into the engine's descriptor register. The engine then reads that descriptor from memory. The descriptor names a rectangle of table slots and points at an array of 32-bit page addresses. The engine reads those entries one by one and writes them into the table in raster order, left to right within a row and rows from top to bottom. It then follows the descriptor's link to the next descriptor, and the walk ends at a link of zero.

Progress is reported in two ways. A status register carries ready, valid, done and error flags. A per-engine 8-bit lane inside a shared interrupt status word carries sticky event bits that software clears by writing ones, and an enable mask per lane gates the interrupt output. Writing zero to the descriptor register abandons any walk in progress and returns the engine to ready. Arbitration between several engines and the address translation that reads the table are handled elsewhere.

Top module: `lut_refill_engine`

## Requirements
- R1: After reset the status register (index 1) reads 0x1 (ready only), the engine's interrupt lane reads 0, its enable lane reads 0x7E, and `irq` is low.
- R2: A descriptor is five 32-bit words at byte offsets 0 to 16: link, first corner {y0[31:16], x0[15:0]}, second corner {y1[31:16], x1[15:0]}, control (bit 0 enables writing, bits [7:4] give the table id driven on `tbl_sel`), and data-array pointer.
- R3: For each enabled descriptor exactly (x1-x0+1)*(y1-y0+1) table writes occur. Write k carries data word k of the array. The writes run row by row from (x0,y0) to (x1,y1), and `tbl_addr` = {y[6:0], x[7:0]}.
- R4: The engine follows nonzero links in order, and a link of zero ends the walk.
- R5: A walk that ends well leaves the status at 0x7 (ready bit 0, valid bit 1, done bit 2), with the error flag (bit 3) clear.
- R6: A descriptor with x1<x0, y1<y0, x1>=256 or y1>=128 makes no table writes, stops the walk, and leaves the status at 0x9.
- R7: A start address, link or data pointer whose low four bits are not zero stops the walk with status 0x9. Writes made by earlier descriptors in the chain remain.
- R8: Writing zero to the descriptor register (index 0) cancels a walk: the status returns to 0x1 and no further table writes occur. A later start then works normally.
- R9: A nonzero write to the descriptor register while a walk is in progress is ignored. The descriptor register keeps the first address and only the first chain is written.
- R10: A descriptor whose control bit 0 is clear makes no writes, but the walk continues through its link.
- R11: The interrupt status (index 2) gives engine ENG_ID the lane [8*ENG_ID+7 : 8*ENG_ID]. In that lane, bit 4 is set when the chain completes, bit 1 on an error, and bit 7 after each descriptor. Writing 1 to a bit clears it, and all other lanes read zero.
- R12: The enable register (index 3) resets to 0x7E in the lane. `irq` is high exactly when some lane status bit has its enable bit set.
- R13: Memory reads are 32-bit aligned, and at most one is outstanding. A request holds its address stable until `mem_ready` accepts it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | RA_W | Register index: 0 descriptor, 1 status, 2 interrupt status, 3 interrupt enable |
| reg_wdata | input | DW | Register write data |
| reg_rdata | output | DW | Register read data for `reg_addr` (combinational) |
| irq | output | 1 | Interrupt request for this engine |
| mem_req | output | 1 | Memory read request valid |
| mem_addr | output | AW | Byte address of the requested word |
| mem_ready | input | 1 | Memory accepts the request this cycle |
| mem_rvalid | input | 1 | Read response valid |
| mem_rdata | input | DW | Read response data |
| tbl_we | output | 1 | Table write strobe |
| tbl_addr | output | X_W+Y_W | Table slot {y, x} |
| tbl_data | output | DW | Table entry value |
| tbl_sel | output | TID_W | Table id from the descriptor control word |

## Verification
Some properties are checked by assertions on every cycle. Table writes must land inside the current rectangle, and the raster counter must never step past the last slot. A pending memory request must hold its address until accepted. The done flag must imply valid and exclude error, and the completion bit of the lane may only rise after a clean finish. The bench scenarios cover what needs a reference model. These are the exact data values and raster order over several rectangle shapes, the following of links, the skipping of disabled descriptors, cancel mid-walk under memory back-pressure, rejection of a second start, the error paths, and the placement, clearing and masking of the interrupt lane.

// File: rtl/lut_refill_pkg.sv
// Package: shared register indices, flag positions and walker state encoding
// for the lookup-table refill engine. Assumes 32-bit descriptor words.
package lut_refill_pkg;

    // register indices on the register port
    localparam int REG_DESC = 0;
    localparam int REG_STAT = 1;
    localparam int REG_IRQS = 2;
    localparam int REG_IRQE = 3;

    // status register bit positions
    localparam int ST_READY = 0;
    localparam int ST_VALID = 1;
    localparam int ST_DONE  = 2;
    localparam int ST_ERR   = 3;

    // interrupt lane bit positions (bit 0 is a table-miss advisory, never raised here)
    localparam int IRQ_MISS = 0;
    localparam int IRQ_ERR  = 1;
    localparam int IRQ_LAST = 4;
    localparam int IRQ_FILL = 7;

    localparam int          LANE_W     = 8;
    localparam logic [7:0]  IRQ_EN_RST = 8'h7E;

    // descriptor geometry
    localparam int DESC_WORDS = 5;
    localparam int W_LINK     = 0;
    localparam int W_CORNER0  = 1;
    localparam int W_CORNER1  = 2;
    localparam int W_CTRL     = 3;
    localparam int W_DPTR     = 4;
    localparam int CTRL_EN    = 0;
    localparam int CTRL_TID   = 4;

    typedef enum logic [2:0] {
        WS_IDLE,
        WS_DREQ,
        WS_DWAIT,
        WS_CHECK,
        WS_EREQ,
        WS_EWAIT,
        WS_LINK,
        WS_DRAIN
    } walk_state_t;

    typedef struct packed {
        logic fin_ok;
        logic fin_err;
        logic desc_fill;
    } walk_evt_t;

endpackage

// File: rtl/lut_refill_raster.sv
// Module: raster position counter. Loads the first corner of a rectangle and
// steps left to right, then top to bottom. Assumes the walker never steps
// once the last slot is reached.
module lut_refill_raster #(
    parameter int X_W = 8,
    parameter int Y_W = 7
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           load,
    input  logic           step,
    input  logic [X_W-1:0] x0,
    input  logic [Y_W-1:0] y0,
    input  logic [X_W-1:0] x1,
    input  logic [Y_W-1:0] y1,
    output logic [X_W-1:0] x,
    output logic [Y_W-1:0] y,
    output logic           last
);

    // current position update: load corner, or advance in raster order
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            x <= '0;
            y <= '0;
        end else if (load) begin
            x <= x0;
            y <= y0;
        end else if (step) begin
            if (x == x1) begin
                x <= x0;
                y <= y + 1'b1;
            end else begin
                x <= x + 1'b1;
            end
        end
    end

    // final slot of the rectangle reached
    assign last = (x == x1) && (y == y1);

    AST_STEP_NOT_PAST_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        step |-> !last); // R3

endmodule

// File: rtl/lut_refill_walker.sv
// Module: descriptor walker. Fetches five-word descriptors, validates them,
// streams the data array into the table in raster order and follows links.
// Assumes a memory port with one outstanding read and in-order responses.
module lut_refill_walker
    import lut_refill_pkg::*;
#(
    parameter int AW         = 32,
    parameter int DW         = 32,
    parameter int TBL_W      = 256,
    parameter int TBL_H      = 128,
    parameter int TID_W      = 4,
    parameter int ALIGN_BITS = 4,
    parameter int X_W        = $clog2(TBL_W),
    parameter int Y_W        = $clog2(TBL_H)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [AW-1:0]    start_addr,
    input  logic             cancel,
    output logic             mem_req,
    output logic [AW-1:0]    mem_addr,
    input  logic             mem_ready,
    input  logic             mem_rvalid,
    input  logic [DW-1:0]    mem_rdata,
    output logic             tbl_we,
    output logic [X_W+Y_W-1:0] tbl_addr,
    output logic [DW-1:0]    tbl_data,
    output logic [TID_W-1:0] tbl_sel,
    output logic             idle,
    output walk_evt_t        evt
);

    localparam int HALF   = DW / 2;
    localparam int WIDX_W = $clog2(DESC_WORDS);
    localparam int WORD_B = DW / 8;

    walk_state_t        state;
    logic [AW-1:0]      cur_desc;
    logic [AW-1:0]      dptr_cur;
    logic [WIDX_W-1:0]  widx;
    logic [DW-1:0]      dw [DESC_WORDS];

    logic [HALF-1:0]    cx0, cy0, cx1, cy1;
    logic               bad_rect, bad_dptr, bad_link, bad_start;
    logic               desc_en, link_zero, in_flight;
    logic               r_load, r_step, r_last;
    logic [X_W-1:0]     rx;
    logic [Y_W-1:0]     ry;

    // descriptor field decode
    always_comb begin
        cx0       = dw[W_CORNER0][HALF-1:0];
        cy0       = dw[W_CORNER0][DW-1:HALF];
        cx1       = dw[W_CORNER1][HALF-1:0];
        cy1       = dw[W_CORNER1][DW-1:HALF];
        bad_rect  = (cx1 < cx0) || (cy1 < cy0) ||
                    (cx1 >= HALF'(TBL_W)) || (cy1 >= HALF'(TBL_H));
        bad_dptr  = |dw[W_DPTR][ALIGN_BITS-1:0];
        link_zero = (dw[W_LINK] == '0);
        bad_link  = |dw[W_LINK][ALIGN_BITS-1:0];
        bad_start = |start_addr[ALIGN_BITS-1:0];
        desc_en   = dw[W_CTRL][CTRL_EN];
    end

    // a read has been accepted whose response has not been consumed yet
    assign in_flight = (((state == WS_DWAIT) || (state == WS_EWAIT)) && !mem_rvalid) ||
                       (((state == WS_DREQ) || (state == WS_EREQ)) && mem_ready);

    // memory request generation
    always_comb begin
        mem_req  = (state == WS_DREQ) || (state == WS_EREQ);
        mem_addr = (state == WS_EREQ) ? dptr_cur
                                      : cur_desc + AW'(widx) * AW'(WORD_B);
    end

    // raster control and table write port
    always_comb begin
        r_load   = (state == WS_CHECK);
        r_step   = (state == WS_EWAIT) && mem_rvalid && !r_last && !cancel;
        tbl_we   = (state == WS_EWAIT) && mem_rvalid && !cancel;
        tbl_addr = {ry, rx};
        tbl_data = mem_rdata;
        tbl_sel  = dw[W_CTRL][CTRL_TID +: TID_W];
        idle     = (state == WS_IDLE);
    end

    // completion and error events for the register block
    always_comb begin
        evt.fin_ok    = !cancel && (state == WS_LINK) && link_zero;
        evt.desc_fill = !cancel && (state == WS_LINK);
        evt.fin_err   = !cancel && (((state == WS_IDLE) && start && bad_start) ||
                                    ((state == WS_CHECK) && (bad_rect || bad_dptr)) ||
                                    ((state == WS_LINK) && !link_zero && bad_link));
    end

    // walk sequencer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= WS_IDLE;
            cur_desc <= '0;
            dptr_cur <= '0;
            widx     <= '0;
            for (int i = 0; i < DESC_WORDS; i++) dw[i] <= '0;
        end else if (cancel && (state != WS_IDLE)) begin
            state <= in_flight ? WS_DRAIN : WS_IDLE;
        end else begin
            case (state)
                WS_IDLE: begin
                    if (start && !bad_start) begin
                        cur_desc <= start_addr;
                        widx     <= '0;
                        state    <= WS_DREQ;
                    end
                end
                WS_DREQ: begin
                    if (mem_ready) state <= WS_DWAIT;
                end
                WS_DWAIT: begin
                    if (mem_rvalid) begin
                        dw[widx] <= mem_rdata;
                        if (widx == WIDX_W'(DESC_WORDS - 1)) begin
                            state <= WS_CHECK;
                        end else begin
                            widx  <= widx + 1'b1;
                            state <= WS_DREQ;
                        end
                    end
                end
                WS_CHECK: begin
                    if (bad_rect || bad_dptr) begin
                        state <= WS_IDLE;
                    end else if (!desc_en) begin
                        state <= WS_LINK;
                    end else begin
                        dptr_cur <= dw[W_DPTR];
                        state    <= WS_EREQ;
                    end
                end
                WS_EREQ: begin
                    if (mem_ready) state <= WS_EWAIT;
                end
                WS_EWAIT: begin
                    if (mem_rvalid) begin
                        dptr_cur <= dptr_cur + AW'(WORD_B);
                        state    <= r_last ? WS_LINK : WS_EREQ;
                    end
                end
                WS_LINK: begin
                    if (link_zero || bad_link) begin
                        state <= WS_IDLE;
                    end else begin
                        cur_desc <= dw[W_LINK];
                        widx     <= '0;
                        state    <= WS_DREQ;
                    end
                end
                WS_DRAIN: begin
                    if (mem_rvalid) state <= WS_IDLE;
                end
                default: state <= WS_IDLE;
            endcase
        end
    end

    lut_refill_raster #(
        .X_W (X_W),
        .Y_W (Y_W)
    ) raster_i (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (r_load),
        .step  (r_step),
        .x0    (cx0[X_W-1:0]),
        .y0    (cy0[Y_W-1:0]),
        .x1    (cx1[X_W-1:0]),
        .y1    (cy1[Y_W-1:0]),
        .x     (rx),
        .y     (ry),
        .last  (r_last)
    );

    AST_WE_IN_RECT: assert property (@(posedge clk) disable iff (!rst_n)
        tbl_we |-> (HALF'(rx) >= cx0) && (HALF'(rx) <= cx1) &&
                   (HALF'(ry) >= cy0) && (HALF'(ry) <= cy1)); // R3
    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ready && !cancel) |=> (mem_req && $stable(mem_addr))); // R13
    AST_WORD_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (mem_addr[1:0] == 2'b00)); // R13
    AST_FIN_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(evt.fin_ok && evt.fin_err)); // R5

endmodule

// File: rtl/lut_refill_regs.sv
// Module: register block. Decodes start and cancel from descriptor-register
// writes, keeps the sticky status flags, the engine's interrupt lane with
// write-one-to-clear, and its enable mask. Assumes DW >= 8*(ENG_ID+1).
module lut_refill_regs
    import lut_refill_pkg::*;
#(
    parameter int AW     = 32,
    parameter int DW     = 32,
    parameter int RA_W   = 2,
    parameter int ENG_ID = 0
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            reg_we,
    input  logic [RA_W-1:0] reg_addr,
    input  logic [DW-1:0]   reg_wdata,
    output logic [DW-1:0]   reg_rdata,
    output logic            irq,
    output logic            start,
    output logic [AW-1:0]   start_addr,
    output logic            cancel,
    input  logic            idle,
    input  walk_evt_t       evt
);

    localparam int LANE_LO = ENG_ID * LANE_W;

    logic [AW-1:0]     desc_q;
    logic              f_valid, f_done, f_err;
    logic [LANE_W-1:0] lane_st, lane_en, lane_set, lane_clr;
    logic              wr_desc, wr_irqs, wr_irqe;

    // write decode
    always_comb begin
        wr_desc    = reg_we && (reg_addr == RA_W'(REG_DESC));
        wr_irqs    = reg_we && (reg_addr == RA_W'(REG_IRQS));
        wr_irqe    = reg_we && (reg_addr == RA_W'(REG_IRQE));
        start      = wr_desc && (reg_wdata != '0);
        cancel     = wr_desc && (reg_wdata == '0);
        start_addr = reg_wdata[AW-1:0];
    end

    // lane event sources
    always_comb begin
        lane_set           = '0;
        lane_set[IRQ_ERR]  = evt.fin_err;
        lane_set[IRQ_LAST] = evt.fin_ok;
        lane_set[IRQ_FILL] = evt.desc_fill;
        lane_clr           = wr_irqs ? reg_wdata[LANE_LO +: LANE_W] : '0;
    end

    // descriptor register: accepted start address, zero on cancel
    always_ff @(posedge clk) begin
        if (!rst_n)                desc_q <= '0;
        else if (cancel)           desc_q <= '0;
        else if (start && idle)    desc_q <= start_addr;
    end

    // sticky status flags, cleared on a new start or a cancel, set by events
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            f_valid <= 1'b0;
            f_done  <= 1'b0;
            f_err   <= 1'b0;
        end else begin
            if (cancel || (start && idle)) begin
                f_valid <= 1'b0;
                f_done  <= 1'b0;
                f_err   <= 1'b0;
            end
            if (evt.fin_ok) begin
                f_valid <= 1'b1;
                f_done  <= 1'b1;
            end
            if (evt.fin_err) f_err <= 1'b1;
        end
    end

    // interrupt lane: set beats write-one-to-clear in the same cycle
    always_ff @(posedge clk) begin
        if (!rst_n) lane_st <= '0;
        else        lane_st <= (lane_st & ~lane_clr) | lane_set;
    end

    // interrupt enable lane
    always_ff @(posedge clk) begin
        if (!rst_n)       lane_en <= IRQ_EN_RST;
        else if (wr_irqe) lane_en <= reg_wdata[LANE_LO +: LANE_W];
    end

    // read mux
    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            RA_W'(REG_DESC): reg_rdata = DW'(desc_q);
            RA_W'(REG_STAT): begin
                reg_rdata[ST_READY] = idle;
                reg_rdata[ST_VALID] = f_valid;
                reg_rdata[ST_DONE]  = f_done;
                reg_rdata[ST_ERR]   = f_err;
            end
            RA_W'(REG_IRQS): reg_rdata[LANE_LO +: LANE_W] = lane_st;
            RA_W'(REG_IRQE): reg_rdata[LANE_LO +: LANE_W] = lane_en;
            default:         reg_rdata = '0;
        endcase
    end

    // interrupt output
    assign irq = |(lane_st & lane_en);

    AST_DONE_HAS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        f_done |-> f_valid); // R5
    AST_ERR_NOT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        !(f_err && f_done)); // R6
    AST_LAST_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lane_st[IRQ_LAST]) |-> $past(evt.fin_ok)); // R11
    AST_MISS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !lane_st[IRQ_MISS]); // R11

endmodule

// File: rtl/lut_refill_engine.sv
// Module: top of the lookup-table refill engine. Joins the register block
// and the descriptor walker. Assumes one engine per instance; its interrupt
// lane position is chosen by ENG_ID.
module lut_refill_engine #(
    parameter int AW     = 32,
    parameter int DW     = 32,
    parameter int RA_W   = 2,
    parameter int ENG_ID = 0,
    parameter int TBL_W  = 256,
    parameter int TBL_H  = 128,
    parameter int TID_W  = 4,
    parameter int X_W    = $clog2(TBL_W),
    parameter int Y_W    = $clog2(TBL_H)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reg_we,
    input  logic [RA_W-1:0]    reg_addr,
    input  logic [DW-1:0]      reg_wdata,
    output logic [DW-1:0]      reg_rdata,
    output logic               irq,
    output logic               mem_req,
    output logic [AW-1:0]      mem_addr,
    input  logic               mem_ready,
    input  logic               mem_rvalid,
    input  logic [DW-1:0]      mem_rdata,
    output logic               tbl_we,
    output logic [X_W+Y_W-1:0] tbl_addr,
    output logic [DW-1:0]      tbl_data,
    output logic [TID_W-1:0]   tbl_sel
);

    import lut_refill_pkg::*;

    logic          start, cancel, idle;
    logic [AW-1:0] start_addr;
    walk_evt_t     evt;

    lut_refill_regs #(
        .AW     (AW),
        .DW     (DW),
        .RA_W   (RA_W),
        .ENG_ID (ENG_ID)
    ) regs_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .reg_we     (reg_we),
        .reg_addr   (reg_addr),
        .reg_wdata  (reg_wdata),
        .reg_rdata  (reg_rdata),
        .irq        (irq),
        .start      (start),
        .start_addr (start_addr),
        .cancel     (cancel),
        .idle       (idle),
        .evt        (evt)
    );

    lut_refill_walker #(
        .AW    (AW),
        .DW    (DW),
        .TBL_W (TBL_W),
        .TBL_H (TBL_H),
        .TID_W (TID_W),
        .X_W   (X_W),
        .Y_W   (Y_W)
    ) walker_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .start_addr (start_addr),
        .cancel     (cancel),
        .mem_req    (mem_req),
        .mem_addr   (mem_addr),
        .mem_ready  (mem_ready),
        .mem_rvalid (mem_rvalid),
        .mem_rdata  (mem_rdata),
        .tbl_we     (tbl_we),
        .tbl_addr   (tbl_addr),
        .tbl_data   (tbl_data),
        .tbl_sel    (tbl_sel),
        .idle       (idle),
        .evt        (evt)
    );

endmodule

// File: tb/lut_refill_engine_tb_top.sv
// Bench: memory model with optional back-pressure, table write log, a vector
// table of single-descriptor rectangles, then directed tests.
module lut_refill_engine_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int ENG        = 1;
    localparam int LO         = ENG * 8;

    // vector table: {x0, y0, x1, y1}
    localparam int NVEC = 5;
    localparam logic [31:0] VEC [NVEC] = '{
        32'h05_03_05_03,
        32'h00_00_07_00,
        32'h0A_02_0A_06,
        32'hFA_78_FF_7F,
        32'h64_32_66_34
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [1:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq;
    logic        mem_req, mem_ready, mem_rvalid;
    logic [31:0] mem_addr, mem_rdata;
    logic        tbl_we;
    logic [14:0] tbl_addr;
    logic [31:0] tbl_data;
    logic [3:0]  tbl_sel;

    int n_chk = 0;
    int n_bad = 0;
    logic done_flag = 1'b0;

    logic [31:0] mem [0:1023];
    logic        stall = 1'b0;
    logic [15:0] cyc = '0;
    logic        rv_q = 1'b0;
    logic [31:0] rd_q = '0;

    logic [31:0] wa_q [$];
    logic [31:0] wd_q [$];
    logic [31:0] ws_q [$];

    always #(CLK_PERIOD/2) clk = ~clk;

    lut_refill_engine #(.ENG_ID(ENG)) dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .reg_we     (reg_we),
        .reg_addr   (reg_addr),
        .reg_wdata  (reg_wdata),
        .reg_rdata  (reg_rdata),
        .irq        (irq),
        .mem_req    (mem_req),
        .mem_addr   (mem_addr),
        .mem_ready  (mem_ready),
        .mem_rvalid (mem_rvalid),
        .mem_rdata  (mem_rdata),
        .tbl_we     (tbl_we),
        .tbl_addr   (tbl_addr),
        .tbl_data   (tbl_data),
        .tbl_sel    (tbl_sel)
    );

    // memory model: one-cycle read latency, ready every other cycle when stalled
    assign mem_ready  = !stall || cyc[0];
    assign mem_rvalid = rv_q;
    assign mem_rdata  = rd_q;
    always @(posedge clk) begin
        cyc  <= cyc + 1'b1;
        rv_q <= mem_req && mem_ready;
        rd_q <= mem[mem_addr[11:2]];
    end

    // table write log
    always @(posedge clk) begin
        if (rst_n && tbl_we) begin
            wa_q.push_back({17'd0, tbl_addr});
            wd_q.push_back(tbl_data);
            ws_q.push_back({28'd0, tbl_sel});
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic reg_write(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0; reg_wdata = '0;
    endtask

    task automatic reg_read(input logic [1:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic wait_ready(input string tag);
        logic [31:0] s;
        for (int i = 0; i < 3000; i++) begin
            reg_read(2'd1, s);
            if (s[0]) return;
        end
        chk({tag, " ready timeout"}, 32'd0, 32'd1);
    endtask

    task automatic clear_log();
        wa_q.delete(); wd_q.delete(); ws_q.delete();
    endtask

    task automatic put_desc(input int base, input logic [31:0] nxt,
                            input int x0, input int y0, input int x1, input int y1,
                            input logic [31:0] ctrl, input logic [31:0] dptr);
        mem[base/4 + 0] = nxt;
        mem[base/4 + 1] = {y0[15:0], x0[15:0]};
        mem[base/4 + 2] = {y1[15:0], x1[15:0]};
        mem[base/4 + 3] = ctrl;
        mem[base/4 + 4] = dptr;
    endtask

    task automatic fill_data(input int dptr, input int n, input logic [15:0] tag);
        for (int k = 0; k < n; k++) mem[dptr/4 + k] = {tag, k[15:0]};
    endtask

    // compare log entries starting at index base with the expected raster walk
    task automatic check_rect(input string tag, input int base, input int x0, input int y0,
                              input int x1, input int y1, input int dptr, input logic [3:0] sel);
        int k = 0;
        for (int y = y0; y <= y1; y++) begin
            for (int x = x0; x <= x1; x++) begin
                logic [31:0] ea;
                ea = {17'd0, y[6:0], x[7:0]};
                if (base + k < wa_q.size()) begin
                    chk({tag, " R3 addr"}, wa_q[base+k], ea);
                    chk({tag, " R3 data"}, wd_q[base+k], mem[dptr/4 + k]);
                    chk({tag, " R2 sel"}, ws_q[base+k], {28'd0, sel});
                end else begin
                    chk({tag, " R3 missing write"}, 32'd0, 32'd1);
                end
                k++;
            end
        end
    endtask

    task automatic run(input logic [31:0] a, input string tag);
        reg_write(2'd0, a);
        wait_ready(tag);
        repeat (2) @(negedge clk);
    endtask

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!done_flag) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] r;
        int c0;
        for (int i = 0; i < 1024; i++) mem[i] = 32'hC0DE_0000 | i;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        reg_read(2'd1, r); chk("R1 status", r, 32'h1);
        reg_read(2'd2, r); chk("R1 irq status", r, 32'h0);
        reg_read(2'd3, r); chk("R12 enable reset", r, 32'h7E << LO);
        chk("R1 irq low", {31'd0, irq}, 32'd0);

        // vector table walk: single descriptor rectangles
        for (int v = 0; v < NVEC; v++) begin
            int x0, y0, x1, y1, n;
            x0 = VEC[v][31:24]; y0 = VEC[v][23:16]; x1 = VEC[v][15:8]; y1 = VEC[v][7:0];
            n  = (x1 - x0 + 1) * (y1 - y0 + 1);
            stall = v[0];
            clear_log();
            put_desc(32'h100, 32'h0, x0, y0, x1, y1, 32'h1 | (v << 4), 32'h200);
            fill_data(32'h200, n, 16'hA000 | v[15:0]);
            run(32'h100, "vec");
            reg_read(2'd1, r); chk("R5 status good", r, 32'h7);
            chk("R3 write count", wa_q.size(), n);
            check_rect("vec", 0, x0, y0, x1, y1, 32'h200, v[3:0]);
            reg_read(2'd2, r); chk("R11 lane last+fill", r, 32'h90 << LO);
            chk("R12 irq high", {31'd0, irq}, 32'd1);
            reg_write(2'd2, 32'hFFFF_FFFF);
            reg_read(2'd2, r); chk("R11 w1c clear", r, 32'h0);
            chk("R12 irq low after clear", {31'd0, irq}, 32'd0);
        end

        // R4 two-descriptor chain under back-pressure
        stall = 1'b1;
        clear_log();
        put_desc(32'h100, 32'h140, 0, 0, 1, 0, 32'h01, 32'h200);
        put_desc(32'h140, 32'h0, 2, 5, 2, 6, 32'h31, 32'h240);
        fill_data(32'h200, 2, 16'hB001);
        fill_data(32'h240, 2, 16'hB002);
        run(32'h100, "chain");
        chk("R4 chain count", wa_q.size(), 4);
        check_rect("R4 first", 0, 0, 0, 1, 0, 32'h200, 4'h0);
        check_rect("R4 second", 2, 2, 5, 2, 6, 32'h240, 4'h3);
        reg_read(2'd1, r); chk("R5 chain status", r, 32'h7);
        reg_write(2'd2, 32'hFFFF_FFFF);

        // R10 disabled descriptor skipped, walk continues
        stall = 1'b0;
        clear_log();
        put_desc(32'h100, 32'h140, 0, 0, 3, 3, 32'h00, 32'h200);
        put_desc(32'h140, 32'h0, 7, 7, 8, 7, 32'h01, 32'h240);
        run(32'h100, "skip");
        chk("R10 only enabled writes", wa_q.size(), 2);
        check_rect("R10", 0, 7, 7, 8, 7, 32'h240, 4'h0);
        reg_read(2'd1, r); chk("R10 status", r, 32'h7);
        reg_write(2'd2, 32'hFFFF_FFFF);

        // R6 malformed rectangle x1<x0
        clear_log();
        put_desc(32'h100, 32'h0, 5, 0, 4, 0, 32'h01, 32'h200);
        run(32'h100, "bad rect");
        reg_read(2'd1, r); chk("R6 status err", r, 32'h9);
        chk("R6 no writes", wa_q.size(), 0);
        reg_read(2'd2, r); chk("R11 lane err", r, 32'h02 << LO);
        chk("R12 irq on err", {31'd0, irq}, 32'd1);
        reg_write(2'd2, 32'hFFFF_FFFF);

        // R6 out of range y1, second descriptor in chain; first one's writes remain
        clear_log();
        put_desc(32'h100, 32'h140, 1, 1, 1, 1, 32'h01, 32'h200);
        put_desc(32'h140, 32'h0, 0, 0, 0, 128, 32'h01, 32'h240);
        run(32'h100, "range");
        reg_read(2'd1, r); chk("R6 range status", r, 32'h9);
        chk("R6 range writes", wa_q.size(), 1);
        reg_read(2'd2, r); chk("R11 err and fill, no last", r, 32'h82 << LO);
        reg_write(2'd2, 32'hFFFF_FFFF);

        // R7 misaligned start address
        clear_log();
        run(32'h104, "mis start");
        reg_read(2'd1, r); chk("R7 start status", r, 32'h9);
        chk("R7 start no writes", wa_q.size(), 0);

        // R7 misaligned data pointer
        put_desc(32'h100, 32'h0, 0, 0, 1, 0, 32'h01, 32'h208);
        run(32'h100, "mis dptr");
        reg_read(2'd1, r); chk("R7 dptr status", r, 32'h9);
        chk("R7 dptr no writes", wa_q.size(), 0);

        // R7 misaligned link after a good descriptor
        put_desc(32'h100, 32'h148, 0, 0, 1, 0, 32'h01, 32'h200);
        run(32'h100, "mis link");
        reg_read(2'd1, r); chk("R7 link status", r, 32'h9);
        chk("R7 link earlier writes kept", wa_q.size(), 2);
        reg_write(2'd2, 32'hFFFF_FFFF);

        // R8 cancel mid-walk under back-pressure
        stall = 1'b1;
        clear_log();
        put_desc(32'h100, 32'h0, 0, 0, 15, 1, 32'h01, 32'h200);
        reg_write(2'd0, 32'h100);
        repeat (30) @(negedge clk);
        reg_write(2'd0, 32'h0);
        repeat (4) @(negedge clk);
        reg_read(2'd1, r); chk("R8 cancel status", r, 32'h1);
        c0 = wa_q.size();
        repeat (60) @(negedge clk);
        chk("R8 no writes after cancel", wa_q.size(), c0);
        chk("R8 partial", {31'd0, (c0 < 32)}, 32'd1);
        reg_read(2'd0, r); chk("R8 desc reg zero", r, 32'h0);
        clear_log();
        put_desc(32'h100, 32'h0, 3, 3, 4, 3, 32'h01, 32'h240);
        run(32'h100, "after cancel");
        reg_read(2'd1, r); chk("R8 restart status", r, 32'h7);
        check_rect("R8 restart", 0, 3, 3, 4, 3, 32'h240, 4'h0);
        reg_write(2'd2, 32'hFFFF_FFFF);

        // R9 second start while busy ignored
        clear_log();
        put_desc(32'h100, 32'h0, 0, 0, 7, 0, 32'h01, 32'h200);
        put_desc(32'h140, 32'h0, 20, 20, 20, 20, 32'h01, 32'h240);
        reg_write(2'd0, 32'h100);
        repeat (3) @(negedge clk);
        reg_write(2'd0, 32'h140);
        wait_ready("busy");
        repeat (2) @(negedge clk);
        chk("R9 only first chain", wa_q.size(), 8);
        reg_read(2'd0, r); chk("R9 desc keeps first", r, 32'h100);
        reg_read(2'd1, r); chk("R9 status", r, 32'h7);
        reg_write(2'd2, 32'hFFFF_FFFF);
        stall = 1'b0;

        // R12 enable mask gates irq
        reg_write(2'd3, 32'h0);
        put_desc(32'h100, 32'h0, 0, 0, 0, 0, 32'h01, 32'h200);
        run(32'h100, "mask");
        reg_read(2'd2, r); chk("R11 lane set while masked", r, 32'h90 << LO);
        chk("R12 irq masked", {31'd0, irq}, 32'd0);
        reg_write(2'd3, 32'h80 << LO);
        @(negedge clk);
        chk("R12 irq via fill enable", {31'd0, irq}, 32'd1);
        reg_write(2'd2, 32'h10 << LO);
        reg_read(2'd2, r); chk("R11 partial w1c", r, 32'h80 << LO);
        reg_write(2'd2, 32'h0000_00FF);
        reg_read(2'd2, r); chk("R11 other lane write no effect", r, 32'h80 << LO);

        done_flag = 1'b1;
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule